// File: doc/BRIEF.md
# Protection Table Entry Cache with Scoped Invalidation

This block is a small, fully associative cache of memory-protection-table entries, as a DMA permission checker would keep it. Each entry is tagged by a supervisor domain ID and a 4 KiB physical page number and carries an opaque payload. A fill port writes entries and a lookup port reads them, so the cache can be exercised on its own. The table walk and the decoding of permissions happen outside this block.

The main function is invalidation. A command carries a domain-valid flag, a domain ID, a page-valid flag, a size bit and a page number. The two flags choose the scope: everything, one domain, one address range across all domains, or one address range within one domain. With the size bit clear the range is a single 4 KiB page. With the size bit set it is a naturally aligned power-of-two range. The page number's trailing ones encode its size: if x is the position of the lowest 0 bit, the range spans 2^(x+1) pages. Every covered entry is cleared at the clock edge that accepts the command, and a done pulse follows one cycle later.

Top module: `ptc_cache`

## Requirements
- R1: After reset no entry is valid: every lookup misses and `inv_done_o` is 0.
- R2: A fill of (domain, page, data) makes a later lookup with the same domain and page hit with that data. A lookup that differs in domain or page misses. A lookup that misses returns data 0. Lookup results are combinational from the current cache contents.
- R3: An invalidate with both flags at 0 clears every entry of every domain.
- R4: An invalidate with only the domain flag set clears exactly the entries of that domain and keeps the others.
- R5: An invalidate with only the page flag set and size bit 0 clears the entries whose page equals the command page, in all domains, and keeps the others.
- R6: With the size bit at 1, the range covers the 2^(x+1) pages from the command page with bits x..0 cleared upward, where x is the position of the lowest 0 bit of the command page. A page number of all ones covers every page.
- R7: An invalidate with both flags set clears only the entries that are in the range and also belong to the domain.
- R8: The domain field has no effect when the domain flag is 0. The page and size fields have no effect when the page flag is 0.
- R9: `inv_done_o` is high for exactly the one cycle after each cycle in which `inv_valid_i` was high, and low otherwise. A lookup in the cycle after the command never hits a cleared entry.
- R10: A fill in the same cycle as an invalidate that covers the fill's tag leaves no valid entry for that tag. A fill that the invalidate does not cover is written normally.
- R11: A fill whose tag is already cached overwrites that entry's data. Otherwise the fill uses the lowest-indexed free entry. When all 8 entries are valid, it evicts entries in rotation starting at entry 0, and the rotation advances only on such evictions. No two valid entries share a tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fill_valid_i | input | 1 | Write an entry this cycle |
| fill_sdid_i | input | SDID_W | Domain tag of the fill |
| fill_ppn_i | input | PPN_W | Page tag of the fill |
| fill_data_i | input | DATA_W | Payload of the fill |
| lookup_valid_i | input | 1 | Look up a tag this cycle |
| lookup_sdid_i | input | SDID_W | Domain tag to look up |
| lookup_ppn_i | input | PPN_W | Page tag to look up |
| lookup_hit_o | output | 1 | Lookup matched a valid entry |
| lookup_data_o | output | DATA_W | Payload of the hit, 0 on a miss |
| inv_valid_i | input | 1 | Invalidate command this cycle |
| inv_sdid_v_i | input | 1 | Restrict to one domain |
| inv_sdid_i | input | SDID_W | Domain of the command |
| inv_ppn_v_i | input | 1 | Restrict to an address range |
| inv_size_i | input | 1 | 0: single page, 1: range encoded in trailing ones |
| inv_ppn_i | input | PPN_W | Page or range of the command |
| inv_done_o | output | 1 | Completion pulse, one cycle after the command |

## Verification
Lookup results are combinational, so they are due in the same cycle as the lookup inputs and reflect every fill and invalidate accepted at the previous clock edge. The done pulse is due exactly one cycle after the command. The bench drives its inputs 2 ns after the rising edge. At each falling edge it compares the outputs with a behavioural model that the same rising edge has advanced, so every result is checked in the cycle it is due and never earlier.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic [1:0] {FILL_HIT, FILL_FREE, FILL_EVICT} fill_route_e;

  // bits the range check ignores: up to and including the lowest zero bit
  function automatic logic [63:0] napot_skip(input logic [63:0] ppn, input logic size);
    napot_skip = size ? (ppn ^ (ppn + 64'd1)) : 64'd0;
  endfunction
endpackage

// File: rtl/ptc_scope_match.sv
module ptc_scope_match #(
  parameter int unsigned SDID_W = 8,
  parameter int unsigned PPN_W  = 44
) (
  input  logic [SDID_W-1:0] tag_sdid_i,
  input  logic [PPN_W-1:0]  tag_ppn_i,
  input  logic              sdid_v_i,
  input  logic [SDID_W-1:0] sdid_i,
  input  logic              ppn_v_i,
  input  logic              size_i,
  input  logic [PPN_W-1:0]  ppn_i,
  output logic              match_o
);
  logic [63:0] skip, diff;
  logic sd_ok, pg_ok;

  always_comb begin
    skip    = ptc_pkg::napot_skip(64'(ppn_i), size_i);
    diff    = 64'(tag_ppn_i ^ ppn_i) & ~skip;
    sd_ok   = !sdid_v_i || (tag_sdid_i == sdid_i);
    pg_ok   = !ppn_v_i || (diff == 64'd0);
    match_o = sd_ok && pg_ok;
  end
endmodule

// File: rtl/ptc_victim_sel.sv
module ptc_victim_sel #(
  parameter int unsigned N_ENTRIES = 8,
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0] valid_i,
  input  logic [N_ENTRIES-1:0] same_i,
  input  logic [IDX_W-1:0]     rr_i,
  output logic [N_ENTRIES-1:0] sel_o,
  output ptc_pkg::fill_route_e route_o
);
  logic [IDX_W-1:0] hit_idx, free_idx;
  logic hit_any, free_any;

  always_comb begin
    hit_idx  = '0;
    free_idx = '0;
    hit_any  = 1'b0;
    free_any = 1'b0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (same_i[i]) begin
        hit_idx = IDX_W'(i);
        hit_any = 1'b1;
      end
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        free_any = 1'b1;
      end
    end
    sel_o = '0;
    if (hit_any) begin
      sel_o[hit_idx] = 1'b1;
      route_o = ptc_pkg::FILL_HIT;
    end else if (free_any) begin
      sel_o[free_idx] = 1'b1;
      route_o = ptc_pkg::FILL_FREE;
    end else begin
      sel_o[rr_i] = 1'b1;
      route_o = ptc_pkg::FILL_EVICT;
    end
  end
endmodule

// File: rtl/ptc_lookup.sv
module ptc_lookup #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned SDID_W    = 8,
  parameter int unsigned PPN_W     = 44,
  parameter int unsigned DATA_W    = 16
) (
  input  logic [N_ENTRIES-1:0]             valid_i,
  input  logic [N_ENTRIES-1:0][SDID_W-1:0] sdid_i,
  input  logic [N_ENTRIES-1:0][PPN_W-1:0]  ppn_i,
  input  logic [N_ENTRIES-1:0][DATA_W-1:0] data_i,
  input  logic                             req_i,
  input  logic [SDID_W-1:0]                req_sdid_i,
  input  logic [PPN_W-1:0]                 req_ppn_i,
  output logic [N_ENTRIES-1:0]             hit_vec_o,
  output logic                             hit_o,
  output logic [DATA_W-1:0]                data_o
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign hit_vec_o[g] = req_i && valid_i[g] &&
                          (sdid_i[g] == req_sdid_i) && (ppn_i[g] == req_ppn_i);
  end

  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_ENTRIES; i++)
      if (hit_vec_o[i]) data_o = data_o | data_i[i];
  end

  assign hit_o = |hit_vec_o;
endmodule

// File: rtl/ptc_cache.sv
module ptc_cache #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned SDID_W    = 8,
  parameter int unsigned PPN_W     = 44,
  parameter int unsigned DATA_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_valid_i,
  input  logic [SDID_W-1:0] fill_sdid_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              lookup_valid_i,
  input  logic [SDID_W-1:0] lookup_sdid_i,
  input  logic [PPN_W-1:0]  lookup_ppn_i,
  output logic              lookup_hit_o,
  output logic [DATA_W-1:0] lookup_data_o,
  input  logic              inv_valid_i,
  input  logic              inv_sdid_v_i,
  input  logic [SDID_W-1:0] inv_sdid_i,
  input  logic              inv_ppn_v_i,
  input  logic              inv_size_i,
  input  logic [PPN_W-1:0]  inv_ppn_i,
  output logic              inv_done_o
);
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [N_ENTRIES-1:0]             valid_q;
  logic [N_ENTRIES-1:0][SDID_W-1:0] sdid_q;
  logic [N_ENTRIES-1:0][PPN_W-1:0]  ppn_q;
  logic [N_ENTRIES-1:0][DATA_W-1:0] data_q;
  logic [IDX_W-1:0]                 rr_q;
  logic                             done_q;

  logic [N_ENTRIES-1:0] in_scope, kill, same, sel, hit_vec;
  logic fill_in_scope, fill_we;
  ptc_pkg::fill_route_e route;

  // per-entry scope comparators
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    ptc_scope_match #(.SDID_W(SDID_W), .PPN_W(PPN_W)) u_match (
      .tag_sdid_i(sdid_q[g]),
      .tag_ppn_i (ppn_q[g]),
      .sdid_v_i  (inv_sdid_v_i),
      .sdid_i    (inv_sdid_i),
      .ppn_v_i   (inv_ppn_v_i),
      .size_i    (inv_size_i),
      .ppn_i     (inv_ppn_i),
      .match_o   (in_scope[g])
    );
    assign kill[g] = inv_valid_i && valid_q[g] && in_scope[g];
    assign same[g] = valid_q[g] && (sdid_q[g] == fill_sdid_i) && (ppn_q[g] == fill_ppn_i);
  end

  // the incoming fill is screened by the same rule
  ptc_scope_match #(.SDID_W(SDID_W), .PPN_W(PPN_W)) u_fill_match (
    .tag_sdid_i(fill_sdid_i),
    .tag_ppn_i (fill_ppn_i),
    .sdid_v_i  (inv_sdid_v_i),
    .sdid_i    (inv_sdid_i),
    .ppn_v_i   (inv_ppn_v_i),
    .size_i    (inv_size_i),
    .ppn_i     (inv_ppn_i),
    .match_o   (fill_in_scope)
  );

  assign fill_we = fill_valid_i && !(inv_valid_i && fill_in_scope);

  ptc_victim_sel #(.N_ENTRIES(N_ENTRIES)) u_victim (
    .valid_i(valid_q),
    .same_i (same),
    .rr_i   (rr_q),
    .sel_o  (sel),
    .route_o(route)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      rr_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= inv_valid_i;
      for (int i = 0; i < N_ENTRIES; i++) begin
        if (kill[i]) valid_q[i] <= 1'b0;
        if (fill_we && sel[i]) valid_q[i] <= 1'b1;
      end
      if (fill_we && route == ptc_pkg::FILL_EVICT)
        rr_q <= (rr_q == IDX_W'(N_ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  // tag/data storage needs no reset
  always_ff @(posedge clk_i) begin
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (fill_we && sel[i]) begin
        sdid_q[i] <= fill_sdid_i;
        ppn_q[i]  <= fill_ppn_i;
        data_q[i] <= fill_data_i;
      end
    end
  end

  ptc_lookup #(.N_ENTRIES(N_ENTRIES), .SDID_W(SDID_W), .PPN_W(PPN_W), .DATA_W(DATA_W)) u_lookup (
    .valid_i   (valid_q),
    .sdid_i    (sdid_q),
    .ppn_i     (ppn_q),
    .data_i    (data_q),
    .req_i     (lookup_valid_i),
    .req_sdid_i(lookup_sdid_i),
    .req_ppn_i (lookup_ppn_i),
    .hit_vec_o (hit_vec),
    .hit_o     (lookup_hit_o),
    .data_o    (lookup_data_o)
  );

  assign inv_done_o = done_q;
endmodule

// File: rtl/ptc_cache_chk.sv
module ptc_cache_chk #(
  parameter int unsigned N_ENTRIES = 8,
  parameter int unsigned SDID_W    = 8,
  parameter int unsigned PPN_W     = 44,
  parameter int unsigned DATA_W    = 16
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             fill_valid_i,
  input logic [SDID_W-1:0]                fill_sdid_i,
  input logic [PPN_W-1:0]                 fill_ppn_i,
  input logic                             lookup_hit_o,
  input logic [DATA_W-1:0]                lookup_data_o,
  input logic                             inv_valid_i,
  input logic                             inv_sdid_v_i,
  input logic [SDID_W-1:0]                inv_sdid_i,
  input logic                             inv_ppn_v_i,
  input logic                             inv_done_o,
  input logic [N_ENTRIES-1:0]             valid_q,
  input logic [N_ENTRIES-1:0][SDID_W-1:0] sdid_q,
  input logic [N_ENTRIES-1:0][PPN_W-1:0]  ppn_q,
  input logic [N_ENTRIES-1:0]             hit_vec
);
  logic [SDID_W-1:0] cmd_sdid_q, fsd_q;
  logic [PPN_W-1:0]  fppn_q;
  logic dom_alive, fill_alive;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_sdid_q <= '0;
      fsd_q      <= '0;
      fppn_q     <= '0;
    end else begin
      cmd_sdid_q <= inv_sdid_i;
      fsd_q      <= fill_sdid_i;
      fppn_q     <= fill_ppn_i;
    end
  end

  always_comb begin
    dom_alive  = 1'b0;
    fill_alive = 1'b0;
    for (int i = 0; i < N_ENTRIES; i++) begin
      if (valid_q[i] && sdid_q[i] == cmd_sdid_q) dom_alive = 1'b1;
      if (valid_q[i] && sdid_q[i] == fsd_q && ppn_q[i] == fppn_q) fill_alive = 1'b1;
    end
  end

  assert_done_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_i |=> inv_done_o);
  assert_done_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inv_valid_i |=> !inv_done_o);
  assert_flush_all_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && !inv_sdid_v_i && !inv_ppn_v_i) |=> (valid_q == '0));
  assert_domain_gone_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && inv_sdid_v_i && !inv_ppn_v_i) |=> !dom_alive);
  assert_fill_killed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_i && inv_sdid_v_i && !inv_ppn_v_i && fill_valid_i && fill_sdid_i == inv_sdid_i)
    |=> !fill_alive);
  assert_single_hit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  assert_miss_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_hit_o |-> (lookup_data_o == '0));
endmodule

bind ptc_cache ptc_cache_chk #(
  .N_ENTRIES(N_ENTRIES), .SDID_W(SDID_W), .PPN_W(PPN_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fill_valid_i (fill_valid_i),
  .fill_sdid_i  (fill_sdid_i),
  .fill_ppn_i   (fill_ppn_i),
  .lookup_hit_o (lookup_hit_o),
  .lookup_data_o(lookup_data_o),
  .inv_valid_i  (inv_valid_i),
  .inv_sdid_v_i (inv_sdid_v_i),
  .inv_sdid_i   (inv_sdid_i),
  .inv_ppn_v_i  (inv_ppn_v_i),
  .inv_done_o   (inv_done_o),
  .valid_q      (valid_q),
  .sdid_q       (sdid_q),
  .ppn_q        (ppn_q),
  .hit_vec      (hit_vec)
);

// File: tb/ptc_cache_test.sv
`timescale 1ns/1ps
module ptc_cache_test;
  localparam int N = 8;
  localparam int SW = 8;
  localparam int PW = 44;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic fill_v = 0, lk_v = 0, inv_v = 0, inv_sv = 0, inv_pv = 0, inv_s = 0;
  logic [SW-1:0] fill_sd = 0, lk_sd = 0, inv_sd = 0;
  logic [PW-1:0] fill_pp = 0, lk_pp = 0, inv_pp = 0;
  logic [DW-1:0] fill_d = 0;
  logic hit;
  logic [DW-1:0] rdata;
  logic done;

  ptc_cache uut (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_valid_i(fill_v), .fill_sdid_i(fill_sd), .fill_ppn_i(fill_pp), .fill_data_i(fill_d),
    .lookup_valid_i(lk_v), .lookup_sdid_i(lk_sd), .lookup_ppn_i(lk_pp),
    .lookup_hit_o(hit), .lookup_data_o(rdata),
    .inv_valid_i(inv_v), .inv_sdid_v_i(inv_sv), .inv_sdid_i(inv_sd),
    .inv_ppn_v_i(inv_pv), .inv_size_i(inv_s), .inv_ppn_i(inv_pp),
    .inv_done_o(done)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";
  bit finished = 0;

  // behavioural reference model
  bit          m_v [N];
  bit [SW-1:0] m_sd[N];
  bit [PW-1:0] m_pp[N];
  bit [DW-1:0] m_d [N];
  int          m_rr;
  bit          m_done;

  function automatic bit covers(bit [SW-1:0] esd, bit [PW-1:0] epp, bit sv,
                                bit [SW-1:0] sd, bit pv, bit s, bit [PW-1:0] pp);
    longint unsigned lo, span, e;
    int x;
    if (sv && esd != sd) return 1'b0;
    if (!pv) return 1'b1;
    if (!s) return epp == pp;
    x = 0;
    while (x < PW && pp[x]) x++;
    span = 64'd1 << (x + 1);
    lo = {20'd0, pp} & ~(span - 64'd1);
    e = {20'd0, epp};
    return (e >= lo) && (e < lo + span);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
      m_rr = 0;
      m_done = 0;
    end else begin
      int slot;
      bit evict, fcov;
      slot = -1;
      evict = 0;
      m_done = inv_v;
      fcov = inv_v && covers(fill_sd, fill_pp, inv_sv, inv_sd, inv_pv, inv_s, inv_pp);
      for (int i = 0; i < N; i++)
        if (slot < 0 && m_v[i] && m_sd[i] == fill_sd && m_pp[i] == fill_pp) slot = i;
      if (slot < 0)
        for (int i = 0; i < N; i++) if (slot < 0 && !m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        evict = 1;
      end
      if (inv_v)
        for (int i = 0; i < N; i++)
          if (m_v[i] && covers(m_sd[i], m_pp[i], inv_sv, inv_sd, inv_pv, inv_s, inv_pp)) m_v[i] = 0;
      if (fill_v && !fcov) begin
        m_v[slot] = 1;
        m_sd[slot] = fill_sd;
        m_pp[slot] = fill_pp;
        m_d[slot] = fill_d;
        if (evict) m_rr = (m_rr + 1) % N;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit eh;
      bit [DW-1:0] ed;
      eh = 0;
      ed = '0;
      if (lk_v)
        for (int i = 0; i < N; i++)
          if (m_v[i] && m_sd[i] == lk_sd && m_pp[i] == lk_pp) begin
            eh = 1;
            ed = m_d[i];
          end
      n_cmp += 3;
      if (hit !== eh) begin
        n_bad++;
        $display("FAIL %s hit sd=%0h pp=%0h: got %0b exp %0b", cur_req, lk_sd, lk_pp, hit, eh);
      end
      if (rdata !== ed) begin
        n_bad++;
        $display("FAIL %s data: got %0h exp %0h", cur_req, rdata, ed);
      end
      if (done !== m_done) begin
        n_bad++;
        $display("FAIL R9 done: got %0b exp %0b", done, m_done);
      end
    end
  end

  task automatic next();
    @(posedge clk);
    #2;
    fill_v = 0; lk_v = 0; inv_v = 0;
  endtask

  task automatic fill(input int sd, input longint pp, input int d);
    fill_v = 1; fill_sd = SW'(sd); fill_pp = PW'(pp); fill_d = DW'(d);
  endtask

  task automatic inv(input bit sv, input int sd, input bit pv, input bit s, input longint pp);
    inv_v = 1; inv_sv = sv; inv_sd = SW'(sd); inv_pv = pv; inv_s = s; inv_pp = PW'(pp);
  endtask

  task automatic probe(input int sd, input longint pp);
    lk_v = 1; lk_sd = SW'(sd); lk_pp = PW'(pp);
    next();
  endtask

  task automatic load4(input int sd0, input int sd1, input longint p0, input longint p1);
    fill(sd0, p0, 16'h100 + int'(p0)); next();
    fill(sd1, p0, 16'h200 + int'(p0)); next();
    fill(sd0, p1, 16'h300 + int'(p1)); next();
    fill(sd1, p1, 16'h400 + int'(p1)); next();
  endtask

  task automatic probe4(input int sd0, input int sd1, input longint p0, input longint p1);
    probe(sd0, p0); probe(sd1, p0); probe(sd0, p1); probe(sd1, p1);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1: empty after reset
    cur_req = "R1";
    probe(0, 0); probe(1, 5);
    // R2: fill then hit, tag mismatch misses
    cur_req = "R2";
    fill(1, 5, 16'hBEEF); next();
    probe(1, 5); probe(2, 5); probe(1, 6);
    // R3: global flush
    cur_req = "R3";
    load4(2, 3, 'h41, 'h42);
    inv(0, 9, 0, 0, 0); next();
    probe4(2, 3, 'h41, 'h42);
    // R4: one domain
    cur_req = "R4";
    load4(2, 3, 'h41, 'h42);
    inv(1, 2, 0, 0, 0); next();
    probe4(2, 3, 'h41, 'h42);
    inv(0, 0, 0, 0, 0); next();
    // R5: single page in all domains
    cur_req = "R5";
    load4(2, 3, 'h41, 'h42);
    inv(0, 0, 1, 0, 'h41); next();
    probe4(2, 3, 'h41, 'h42);
    inv(0, 0, 0, 0, 0); next();
    // R6: range 0x10..0x17 encoded as 0x13
    cur_req = "R6";
    load4(1, 1, 'h0F, 'h10);
    fill(2, 'h17, 7); next();
    fill(2, 'h18, 8); next();
    inv(0, 0, 1, 1, 'h13); next();
    probe(1, 'h0F); probe(1, 'h10); probe(2, 'h17); probe(2, 'h18);
    load4(1, 2, 'h5, 'h900);
    inv(0, 0, 1, 1, 64'hFFF_FFFF_FFFF); next();
    probe4(1, 2, 'h5, 'h900);
    // R7: domain and range together
    cur_req = "R7";
    load4(2, 3, 'h20, 'h21);
    inv(1, 3, 1, 1, 'h20); next();
    probe4(2, 3, 'h20, 'h21);
    inv(0, 0, 0, 0, 0); next();
    // R8: fields ignored when flag is 0
    cur_req = "R8";
    load4(2, 3, 'h30, 'h31);
    inv(1, 2, 0, 1, 'h30); next();
    probe4(2, 3, 'h30, 'h31);
    load4(2, 3, 'h30, 'h31);
    inv(0, 2, 1, 0, 'h31); next();
    probe4(2, 3, 'h30, 'h31);
    inv(0, 0, 0, 0, 0); next();
    // R9: lookup right after a command, back-to-back commands
    cur_req = "R9";
    fill(4, 'h50, 16'h55); next();
    inv(1, 4, 0, 0, 0); lk_v = 1; lk_sd = 4; lk_pp = 'h50; next();
    probe(4, 'h50);
    inv(0, 0, 0, 0, 0); next();
    inv(0, 0, 0, 0, 0); next();
    next();
    // R10: fill racing an invalidate
    cur_req = "R10";
    fill(5, 'h60, 1); inv(1, 5, 0, 0, 0); next();
    probe(5, 'h60);
    fill(5, 'h61, 2); inv(1, 6, 0, 0, 0); next();
    probe(5, 'h61);
    fill(5, 'h62, 3); inv(0, 0, 1, 1, 'h61); next();
    probe(5, 'h62);
    inv(0, 0, 0, 0, 0); next();
    // R11: overwrite, fill to full, rotation eviction
    cur_req = "R11";
    for (int i = 0; i < N; i++) begin
      fill(7, 'h70 + i, 16'h700 + i); next();
    end
    fill(7, 'h73, 16'hAAAA); next();
    probe(7, 'h73);
    fill(7, 'h80, 16'h800); next();
    fill(7, 'h81, 16'h801); next();
    for (int i = 0; i < N; i++) probe(7, 'h70 + i);
    probe(7, 'h80); probe(7, 'h81);
    // mixed traffic on a small tag space
    cur_req = "R11";
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 1) == 1) fill(int'($urandom_range(0, 3)), longint'($urandom_range(0, 31)), int'($urandom_range(0, 65535)));
      if ($urandom_range(0, 7) == 0)
        inv(1'($urandom_range(0, 1)), int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), longint'($urandom_range(0, 31)));
      lk_v = 1; lk_sd = SW'($urandom_range(0, 3)); lk_pp = PW'($urandom_range(0, 31));
      next();
    end
    next();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule